// File: doc/BRIEF.md
# SPI Flash Address-Mode Tracker

This block holds the 3-byte / 4-byte addressing mode of an SPI flash target. It lives on the target side of the serial bus and keeps the mode only in the serial clock domain. Every command on the bus starts with an 8-bit opcode. The enter-4-byte opcode (0xB7) and the exit-4-byte opcode (0xE9) change the mode at the last opcode bit. No busy flag is raised and no software is involved, so a host can send a read straight after either of them. The block then reports how many address bits follow the opcode in the current command.

Software can also ask for a mode change. A set or clear pulse in the system clock domain is latched as an intent. The intent crosses into the serial domain through a toggle request/acknowledge pair and is committed at the end of the next opcode byte, which is before any address bit arrives. When that opcode is itself an enter-4-byte or exit-4-byte command, the hardware result stands and the software intent is discarded.

The serial-domain mode is returned to the system clock domain through a two-flop synchronizer for register readback. Because the mode never makes a round trip through the system domain, two commands can be separated by a chip-select gap of one system clock period.

Top module: `addr_mode_tracker`

## Requirements
- R1: After reset the mode is 3-byte, `sw_mode_rd` is 0, `addr_valid` is 0 and no software request is pending, so the first command reports `addr_bits` = 24.
- R2: Opcode bits are sampled MSB first on rising `spi_sck` edges while `spi_csb` is low. A high `spi_csb` discards a partial byte and restarts the bit count.
- R3: Opcode 0xB7 sets 4-byte mode at its 8th rising edge, and `addr_bits` reads 32 from that edge.
- R4: Opcode 0xE9 sets 3-byte mode at its 8th rising edge, and `addr_bits` reads 24 from that edge.
- R5: Any other opcode leaves the mode unchanged when no software request is pending. Bits after the opcode byte never change the mode.
- R6: `addr_valid` is low while `spi_csb` is high and during the first seven opcode edges. It is high from the 8th edge until `spi_csb` rises. `addr_bits` is 24 in 3-byte mode and 32 in 4-byte mode, and it is stable while `addr_valid` is high.
- R7: A one-cycle pulse on `sw_set_4b` (4-byte) or `sw_clr_4b` (3-byte), issued at least 3 system cycles before the first edge of a command, is applied at the 8th edge of the next command whose opcode is neither 0xB7 nor 0xE9. The mode and `sw_mode_rd` are unchanged before that edge.
- R8: When that next command's opcode is 0xB7 or 0xE9, the opcode decides the mode and the pending software request is discarded.
- R9: Among several writes made before the request is applied, the latest one wins. A set and a clear in the same cycle count as a clear.
- R10: `sw_mode_rd` equals the serial-domain mode within 3 system clock cycles of a mode change.
- R11: A mode change is used by the very next command even when `spi_csb` is high for only 8 ns with no `spi_sck` edges in between.
- R12: A write made while an earlier request still awaits its acknowledgement is sent again after that acknowledgement. It applies at the following command unless that command's opcode overrides it. Each request is applied at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| sw_set_4b | input | 1 | One-cycle software request for 4-byte mode |
| sw_clr_4b | input | 1 | One-cycle software request for 3-byte mode |
| sw_mode_rd | output | 1 | Synchronized mode for readback (1 = 4-byte) |
| spi_sck | input | 1 | Serial clock from the host |
| rst_spi | input | 1 | Synchronous active-high reset, serial domain |
| spi_csb | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| addr_valid | output | 1 | High once the opcode byte is complete |
| addr_bits | output | 6 | Address bit count of the current command (24 or 32) |

## Verification
The mode and `addr_valid` change at the 8th rising serial edge, with no register in between. The bench therefore samples them 5 ns after the following falling edge, and it checks `addr_valid` low one edge earlier. Readback takes two system flops, so the bench waits three falling system edges after a command before it compares `sw_mode_rd`. A software pulse takes two system cycles to launch its toggle, and the acknowledgement takes about three cycles to return. For that reason the bench leaves three falling system edges after every write and six after every command before its next stimulus, which keeps the reference model's request state aligned with the hardware.

// File: rtl/amt_pkg.sv
package amt_pkg;

    localparam int OPC_BITS  = 8;
    localparam int CNT_W     = $clog2(OPC_BITS);
    localparam logic [OPC_BITS-1:0] OPC_EN4B = 8'hB7;
    localparam logic [OPC_BITS-1:0] OPC_EX4B = 8'hE9;
    localparam int ABITS_3B  = 24;
    localparam int ABITS_4B  = 32;
    localparam int ABITS_W   = $clog2(ABITS_4B + 1);

    typedef enum logic {
        MODE_3B = 1'b0,
        MODE_4B = 1'b1
    } amode_e;

    typedef enum logic [1:0] {
        HW_NONE  = 2'd0,
        HW_ENTER = 2'd1,
        HW_EXIT  = 2'd2
    } hw_cmd_e;

    // Software intent as it crosses domains: toggle plus wanted mode bit.
    typedef struct packed {
        logic tgl;
        logic want;
    } sw_intent_t;

    function automatic hw_cmd_e decode_op(input logic [OPC_BITS-1:0] op);
        case (op)
            OPC_EN4B: return HW_ENTER;
            OPC_EX4B: return HW_EXIT;
            default:  return HW_NONE;
        endcase
    endfunction

    function automatic logic [ABITS_W-1:0] abits_of(input amode_e m);
        return (m == MODE_4B) ? ABITS_W'(ABITS_4B) : ABITS_W'(ABITS_3B);
    endfunction

endpackage

// File: rtl/amt_sync.sv
module amt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/amt_sw_side.sv
module amt_sw_side
    import amt_pkg::*;
(
    input  logic       clk_sys,
    input  logic       rst_sys,
    input  logic       set_req,
    input  logic       clr_req,
    input  logic       ack_s,
    output sw_intent_t intent
);
    logic need;
    logic pending;
    logic wr;
    logic launch;

    assign wr      = set_req | clr_req;
    assign pending = intent.tgl ^ ack_s;
    assign launch  = need & ~pending;

    always_ff @(posedge clk_sys) begin
        if (rst_sys) begin
            intent <= '0;
            need   <= 1'b0;
        end else begin
            if (wr) intent.want <= ~clr_req;
            if (launch) intent.tgl <= ~intent.tgl;
            need <= wr | (need & pending);
        end
    end
endmodule

// File: rtl/amt_spi_core.sv
module amt_spi_core
    import amt_pkg::*;
(
    input  logic                spi_sck,
    input  logic                rst_spi,
    input  logic                spi_csb,
    input  logic                spi_mosi,
    input  sw_intent_t          intent_s,
    output amode_e              mode_4b,
    output logic                ack_tgl,
    output logic                op_last,
    output logic [OPC_BITS-1:0] op_byte,
    output logic                addr_valid,
    output logic [ABITS_W-1:0]  addr_bits
);
    logic [CNT_W-1:0]    cnt;
    logic [OPC_BITS-2:0] shreg;
    logic                done;
    hw_cmd_e             hw_cmd;

    // Opcode capture, cleared asynchronously while chip select is idle.
    always_ff @(posedge spi_sck or posedge spi_csb) begin
        if (spi_csb) begin
            cnt   <= '0;
            shreg <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            shreg <= {shreg[OPC_BITS-3:0], spi_mosi};
            cnt   <= cnt + 1'b1;
            if (cnt == CNT_W'(OPC_BITS - 1)) done <= 1'b1;
        end
    end

    assign op_byte = {shreg, spi_mosi};
    assign op_last = !done && (cnt == CNT_W'(OPC_BITS - 1));
    assign hw_cmd  = decode_op(op_byte);

    // Mode register: the only copy of the addressing mode.
    always_ff @(posedge spi_sck) begin
        if (rst_spi) begin
            mode_4b <= MODE_3B;
            ack_tgl <= 1'b0;
        end else if (op_last) begin
            ack_tgl <= intent_s.tgl;
            case (hw_cmd)
                HW_ENTER: mode_4b <= MODE_4B;
                HW_EXIT:  mode_4b <= MODE_3B;
                default: begin
                    if (intent_s.tgl != ack_tgl) mode_4b <= amode_e'(intent_s.want);
                end
            endcase
        end
    end

    assign addr_valid = done;
    assign addr_bits  = abits_of(mode_4b);
endmodule

// File: rtl/addr_mode_tracker.sv
module addr_mode_tracker
    import amt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_sys,
    input  logic               rst_sys,
    input  logic               sw_set_4b,
    input  logic               sw_clr_4b,
    output logic               sw_mode_rd,
    input  logic               spi_sck,
    input  logic               rst_spi,
    input  logic               spi_csb,
    input  logic               spi_mosi,
    output logic               addr_valid,
    output logic [ABITS_W-1:0] addr_bits
);
    sw_intent_t          intent_sys;
    sw_intent_t          intent_s;
    logic [1:0]          intent_raw_s;
    logic                ack_tgl;
    logic                ack_s;
    amode_e              mode_4b;
    logic                op_last;
    logic [OPC_BITS-1:0] op_byte;

    amt_sw_side u_sw (
        .clk_sys (clk_sys),
        .rst_sys (rst_sys),
        .set_req (sw_set_4b),
        .clr_req (sw_clr_4b),
        .ack_s   (ack_s),
        .intent  (intent_sys)
    );

    amt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk (spi_sck),
        .rst (rst_spi),
        .d   (intent_sys),
        .q   (intent_raw_s)
    );

    assign intent_s = intent_raw_s;

    amt_spi_core u_core (
        .spi_sck    (spi_sck),
        .rst_spi    (rst_spi),
        .spi_csb    (spi_csb),
        .spi_mosi   (spi_mosi),
        .intent_s   (intent_s),
        .mode_4b    (mode_4b),
        .ack_tgl    (ack_tgl),
        .op_last    (op_last),
        .op_byte    (op_byte),
        .addr_valid (addr_valid),
        .addr_bits  (addr_bits)
    );

    amt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk_sys),
        .rst (rst_sys),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    amt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rd_sync (
        .clk (clk_sys),
        .rst (rst_sys),
        .d   (mode_4b),
        .q   (sw_mode_rd)
    );
endmodule

// File: rtl/amt_checker.sv
module amt_checker
    import amt_pkg::*;
(
    input logic                clk_sys,
    input logic                rst_sys,
    input logic                spi_sck,
    input logic                rst_spi,
    input logic                addr_valid,
    input logic [ABITS_W-1:0]  addr_bits,
    input amode_e              mode_4b,
    input logic                op_last,
    input logic [OPC_BITS-1:0] op_byte,
    input sw_intent_t          intent_sys,
    input logic                ack_s
);
    p_en4b_sets_r3: assert property (@(posedge spi_sck) disable iff (rst_spi)
        (op_last && op_byte == OPC_EN4B) |=> (mode_4b == MODE_4B));

    p_ex4b_clears_r4: assert property (@(posedge spi_sck) disable iff (rst_spi)
        (op_last && op_byte == OPC_EX4B) |=> (mode_4b == MODE_3B));

    p_mode_only_at_opcode_r5: assert property (@(posedge spi_sck) disable iff (rst_spi)
        !op_last |=> $stable(mode_4b));

    p_bits_stable_r6: assert property (@(posedge spi_sck) disable iff (rst_spi)
        addr_valid |=> $stable(addr_bits));

    p_one_request_in_flight_r12: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (intent_sys.tgl != $past(intent_sys.tgl)) |-> ($past(intent_sys.tgl) == $past(ack_s)));
endmodule

bind addr_mode_tracker amt_checker u_chk (.*);

// File: tb/tb_addr_mode_tracker.sv
`timescale 1ns/1ps
module tb_addr_mode_tracker;
    logic       clk_sys = 1'b0;
    logic       rst_sys = 1'b1;
    logic       sw_set_4b = 1'b0;
    logic       sw_clr_4b = 1'b0;
    logic       sw_mode_rd;
    logic       spi_sck = 1'b0;
    logic       rst_spi = 1'b1;
    logic       spi_csb = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       addr_valid;
    logic [5:0] addr_bits;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    bit m_mode  = 1'b0;   // 1 = 4-byte
    bit m_out   = 1'b0;   // request launched, not yet consumed
    bit m_again = 1'b0;   // write made while a request was outstanding
    bit m_val   = 1'b0;

    addr_mode_tracker dut (.*);

    always #4 clk_sys = ~clk_sys;   // 125 MHz

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_bits(input bit m);
        return m ? 32 : 24;
    endfunction

    task automatic sw_write(input bit set, input bit clr);
        @(negedge clk_sys);
        sw_set_4b = set;
        sw_clr_4b = clr;
        @(negedge clk_sys);
        sw_set_4b = 1'b0;
        sw_clr_4b = 1'b0;
        if (!m_out) m_out = 1'b1;
        else        m_again = 1'b1;
        m_val = !clr;
        repeat (3) @(negedge clk_sys);
    endtask

    task automatic do_cmd(input logic [7:0] op, input string tag, input int gap_ns, input int extra);
        logic [5:0] held;
        if (op == 8'hB7)      m_mode = 1'b1;
        else if (op == 8'hE9) m_mode = 1'b0;
        else if (m_out)       m_mode = m_val;
        if (m_out) begin
            m_out   = m_again;
            m_again = 1'b0;
        end
        spi_csb = 1'b0;
        #5;
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = op[i];
            #5 spi_sck = 1'b1;
            #10 spi_sck = 1'b0;
            #5;
            if (i == 1) chk(addr_valid == 1'b0, "R6 valid early", int'(addr_valid), 0);
        end
        chk(addr_valid == 1'b1, "R6 valid at byte end", int'(addr_valid), 1);
        chk(addr_bits == 6'(exp_bits(m_mode)), tag, int'(addr_bits), exp_bits(m_mode));
        held = addr_bits;
        for (int k = 0; k < extra; k++) begin
            spi_mosi = $urandom % 2;
            #5 spi_sck = 1'b1;
            #10 spi_sck = 1'b0;
            #5;
        end
        if (extra > 0) chk(addr_bits == held, "R5 R6 bits after opcode", int'(addr_bits), int'(held));
        spi_csb = 1'b1;
        #1;
        chk(addr_valid == 1'b0, "R6 valid idle", int'(addr_valid), 0);
        #(gap_ns - 1);
    endtask

    task automatic settle_and_read(input string tag);
        repeat (6) @(negedge clk_sys);
        chk(sw_mode_rd == m_mode, tag, int'(sw_mode_rd), int'(m_mode));
    endtask

    initial begin
        repeat (200000) @(posedge clk_sys);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd1234);
        repeat (4) begin
            #10 spi_sck = 1'b1;
            #10 spi_sck = 1'b0;
        end
        repeat (3) @(negedge clk_sys);
        rst_sys = 1'b0;
        rst_spi = 1'b0;
        @(negedge clk_sys);

        // R1 reset state
        chk(addr_valid == 1'b0, "R1 addr_valid", int'(addr_valid), 0);
        chk(sw_mode_rd == 1'b0, "R1 readback", int'(sw_mode_rd), 0);
        do_cmd(8'h03, "R1 first command bits", 20, 4);
        settle_and_read("R1 readback after cmd");

        // R3 enter, R10 readback latency, R5 plain opcode keeps mode
        do_cmd(8'hB7, "R3 enter", 1, 0);
        repeat (3) @(negedge clk_sys);
        chk(sw_mode_rd == 1'b1, "R10 readback latency", int'(sw_mode_rd), 1);
        repeat (3) @(negedge clk_sys);
        do_cmd(8'h0B, "R5 plain opcode", 20, 6);
        settle_and_read("R10 readback");

        // R2 partial byte aborted by chip select
        spi_csb = 1'b0;
        #5;
        for (int i = 7; i >= 3; i--) begin
            spi_mosi = r[0] | 1'b1;
            spi_mosi = 8'hE9 >> i;
            #5 spi_sck = 1'b1;
            #10 spi_sck = 1'b0;
            #5;
        end
        spi_csb = 1'b1;
        #10;
        chk(addr_valid == 1'b0, "R2 partial byte", int'(addr_valid), 0);
        do_cmd(8'h03, "R2 count restarts", 20, 2);
        settle_and_read("R2 readback");

        // R4 exit, R11 back-to-back with 8 ns gaps
        do_cmd(8'hE9, "R4 exit", 8, 0);
        do_cmd(8'h03, "R11 exit seen next", 8, 0);
        do_cmd(8'hB7, "R11 enter", 8, 0);
        do_cmd(8'h0B, "R11 enter seen next", 8, 1);
        do_cmd(8'hE9, "R11 exit", 8, 0);
        do_cmd(8'h13, "R11 exit seen next", 20, 0);
        settle_and_read("R11 readback");

        // R7 software set applied at next opcode
        sw_write(1'b1, 1'b0);
        chk(sw_mode_rd == 1'b0, "R7 no change before cmd", int'(sw_mode_rd), 0);
        do_cmd(8'h03, "R7 sw set applied", 20, 3);
        settle_and_read("R7 readback");
        sw_write(1'b0, 1'b1);
        do_cmd(8'h0B, "R7 sw clear applied", 20, 0);
        settle_and_read("R7 readback clear");

        // R8 hardware opcode overrides and drops
        sw_write(1'b1, 1'b0);
        do_cmd(8'hE9, "R8 exit wins", 20, 0);
        settle_and_read("R8 readback");
        do_cmd(8'h03, "R8 request dropped", 20, 0);
        settle_and_read("R8 readback dropped");

        // R9 latest write wins, same-cycle clear wins
        sw_write(1'b1, 1'b0);
        sw_write(1'b0, 1'b1);
        sw_write(1'b1, 1'b0);
        do_cmd(8'h03, "R9 latest wins", 20, 0);
        settle_and_read("R9 readback");
        do_cmd(8'hB7, "R12 resend dropped", 20, 0);
        settle_and_read("R12 readback");
        sw_write(1'b1, 1'b1);
        do_cmd(8'h03, "R9 clear wins", 20, 0);
        settle_and_read("R9 readback clear");

        // R12 resend after ack, applied once
        sw_write(1'b1, 1'b0);
        sw_write(1'b0, 1'b1);
        do_cmd(8'hB7, "R12 first dropped", 20, 0);
        settle_and_read("R12 readback");
        do_cmd(8'h03, "R12 resend applied", 20, 0);
        settle_and_read("R12 readback resend");
        do_cmd(8'hB7, "R12 enter", 20, 0);
        settle_and_read("R12 readback enter");
        do_cmd(8'h03, "R12 not reapplied", 20, 0);
        settle_and_read("R12 readback final");

        // Constrained random mix
        for (int it = 0; it < 300; it++) begin
            int sel;
            sel = $urandom % 10;
            if (sel < 3) begin
                int w;
                w = $urandom % 3;
                sw_write(w != 1, w != 0);
            end else begin
                logic [7:0] op;
                int p;
                p = $urandom % 10;
                if (p < 3)      op = 8'hB7;
                else if (p < 6) op = 8'hE9;
                else            op = 8'($urandom);
                do_cmd(op, (op == 8'hB7) ? "R3 random" : (op == 8'hE9) ? "R4 random" : "R7 random",
                       8 + ($urandom % 33), $urandom % 5);
                settle_and_read("R10 random");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule